// File: doc/BRIEF.md
# Frame-Sync Power-Down Controller

This block decides whether a serial voice-codec interface is powered up, and whether its transmit data pin may be driven. It watches a power-down control pin and the transmit and receive frame-sync lines, all of them synchronous to one system clock. The block comes out of reset powered down.

It powers up on the first sync edge on either line, provided the control pin is low. It powers down when the control pin is driven high, or when neither sync line has produced an edge for a programmable number of clocks. That number defaults to 1 ms at the system clock rate.

After power-up the transmit output stays released (high impedance) until a second transmit sync edge has been seen. This keeps the first, partly encoded frame off the bus. Clock generation and the analog power switches are outside this block. The surrounding logic uses `powered_up` to gate those circuits and `tx_drive_en` as the output-enable of the data pin.

Top module: `fspd_ctrl`

## Requirements
- R1: During and after synchronous reset, `powered_up` and `tx_drive_en` are both 0.
- R2: When `pdn_pin` is 1 at a rising clock edge, `powered_up` is 0 after that edge. This holds whatever the sync lines do, because the pin has priority over sync activity.
- R3: While powered down with `pdn_pin` at 0, a sync edge on `tx_sync` or `rx_sync` sets `powered_up` to 1 after the clock edge that samples it. A sync edge is a clock edge where the line is 1 and was 0 at the previous edge.
- R4: While powered down, with no sync edge on either line, `powered_up` stays 0.
- R5: While powered up with `pdn_pin` at 0, `powered_up` falls to 0 exactly `TIMEOUT_CLKS` clock edges after the edge that sampled the last sync edge on either line. Any sync edge restarts that count.
- R6: A sync line held at 1 for several clocks counts as a single sync edge.
- R7: `tx_drive_en` is 1 only while `powered_up` is 1.
- R8: `tx_drive_en` becomes 1 after the clock edge that samples the second `tx_sync` edge counted since power-up. The edge that causes power-up counts as the first. Receive sync edges are not counted.
- R9: Every entry to power-down clears the transmit-sync count, so two fresh `tx_sync` edges are needed after the next power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_pin | input | 1 | Power-down control, 1 forces power-down |
| tx_sync | input | 1 | Transmit frame sync, synchronous to `clk` |
| rx_sync | input | 1 | Receive frame sync, synchronous to `clk` |
| powered_up | output | 1 | 1 while the interface is powered up |
| tx_drive_en | output | 1 | 1 while the transmit data pin may be driven |

## Verification
A wrong power state shows on `powered_up` one edge after the offending input. A stale transmit-sync count shows only at the next power-up, when `tx_drive_en` rises one frame early or late. The bench therefore cycles power through both the pin path and the timeout path and then re-counts syncs. An off-by-one in the idle timer shifts the fall of `powered_up` by one clock. The bench checks the clock just before the expected fall and the clock at the fall, both after a single pulse and after a restart.

// File: rtl/fspd_pkg.sv
package fspd_pkg;

    typedef enum logic {
        PWR_DOWN = 1'b0,
        PWR_UP   = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } sync_evt_t;

    localparam int unsigned SYNC_LINES  = 2;
    localparam int unsigned TX_NEEDED   = 2;
    localparam int unsigned TXCNT_W     = $clog2(TX_NEEDED + 1);

    function automatic logic [TXCNT_W-1:0] sat_inc(input logic [TXCNT_W-1:0] v);
        if (v >= TXCNT_W'(TX_NEEDED)) begin
            return TXCNT_W'(TX_NEEDED);
        end
        return v + TXCNT_W'(1);
    endfunction

endpackage

// File: rtl/fspd_edge_det.sv
module fspd_edge_det #(
    parameter int unsigned LINES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] rise
);
    logic [LINES-1:0] prev_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= line_in[g];
            end
        end
        assign rise[g] = line_in[g] & ~prev_q[g];

        // R6: a line held high yields no further edge
        p_single_edge_r6: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/fspd_idle_timer.sv
module fspd_idle_timer #(
    parameter int unsigned LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire = active && !restart && (cnt_q == CW'(LIMIT - 1));

    // R5: the idle count never runs past the limit while powered
    p_idle_bound_r5: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q < CW'(LIMIT)));

    // R5: leaving the powered state restarts the count
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0));
endmodule

// File: rtl/fspd_tx_gate.sv
module fspd_tx_gate
    import fspd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_next,
    input  logic tx_edge,
    input  logic pwr_now,
    output logic drive_en
);
    logic [TXCNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_next) begin
            cnt_q <= '0;
        end else if (tx_edge) begin
            cnt_q <= sat_inc(cnt_q);
        end
    end

    assign drive_en = pwr_now && (cnt_q == TXCNT_W'(TX_NEEDED));

    // R9: any entry into power-down leaves the count empty
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !pwr_next |=> (cnt_q == '0));

    // R8: count saturates at the required number
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TXCNT_W'(TX_NEEDED));
endmodule

// File: rtl/fspd_ctrl.sv
module fspd_ctrl
    import fspd_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 100_000_000,
    parameter int unsigned TIMEOUT_CLKS = CLK_HZ / 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_pin,
    input  logic tx_sync,
    input  logic rx_sync,
    output logic powered_up,
    output logic tx_drive_en
);
    pwr_state_e state_q, state_d;
    sync_evt_t  evt;
    logic [SYNC_LINES-1:0] rise_vec;
    logic any_edge;
    logic idle_expire;

    fspd_edge_det #(.LINES(SYNC_LINES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in ({tx_sync, rx_sync}),
        .rise    (rise_vec)
    );

    assign evt      = sync_evt_t'(rise_vec);
    assign any_edge = evt.tx | evt.rx;

    fspd_idle_timer #(.LIMIT(TIMEOUT_CLKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == PWR_UP),
        .restart (any_edge),
        .expire  (idle_expire)
    );

    always_comb begin
        state_d = state_q;
        if (pdn_pin) begin
            state_d = PWR_DOWN;
        end else begin
            unique case (state_q)
                PWR_DOWN: if (any_edge)    state_d = PWR_UP;
                PWR_UP:   if (idle_expire) state_d = PWR_DOWN;
                default:                   state_d = PWR_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    assign powered_up = (state_q == PWR_UP);

    fspd_tx_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pwr_next (state_d == PWR_UP),
        .tx_edge  (evt.tx),
        .pwr_now  (powered_up),
        .drive_en (tx_drive_en)
    );

    // R2: control pin forces power-down on the next edge
    p_pin_down_r2: assert property (@(posedge clk) disable iff (rst)
        pdn_pin |=> !powered_up);

    // R3: a sync edge wakes the block when the pin allows
    p_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (!pdn_pin && !powered_up && (tx_sync || rx_sync) && any_edge) |=> powered_up);

    // R4: no sync edge, no wake-up
    p_stay_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!powered_up && !any_edge) |=> !powered_up);

    // R7: the data pin is only driven while powered
    p_drive_pwr_r7: assert property (@(posedge clk) disable iff (rst)
        tx_drive_en |-> powered_up);

    // R1: reset leaves everything released
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!powered_up && !tx_drive_en));
endmodule

// File: tb/tb_fspd_ctrl.sv
module tb_fspd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_OUT      = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pdn_pin = 1'b0;
    logic tx_sync = 1'b0;
    logic rx_sync = 1'b0;
    logic powered_up, tx_drive_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    fspd_ctrl #(.CLK_HZ(40_000), .TIMEOUT_CLKS(T_OUT)) dut (
        .clk(clk), .rst(rst), .pdn_pin(pdn_pin), .tx_sync(tx_sync),
        .rx_sync(rx_sync), .powered_up(powered_up), .tx_drive_en(tx_drive_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic pu_exp, input logic de_exp);
        n_checks++;
        if (powered_up !== pu_exp || tx_drive_en !== de_exp) begin
            n_fail++;
            $display("FAIL %s: powered_up=%b tx_drive_en=%b expected %b %b",
                     req, powered_up, tx_drive_en, pu_exp, de_exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        tx_sync = 1'b1; @(negedge clk);
        tx_sync = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_rx();
        rx_sync = 1'b1; @(negedge clk);
        rx_sync = 1'b0; @(negedge clk);
    endtask

    task automatic force_down();
        pdn_pin = 1'b1; @(negedge clk);
        pdn_pin = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0; @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0);
    endtask

    task automatic t_stay_down();
        idle(20);
        check("R4 no sync", 1'b0, 1'b0);
    endtask

    task automatic t_pin_blocks();
        pdn_pin = 1'b1;
        pulse_tx(); pulse_rx(); pulse_tx();
        check("R2 pin high blocks wake", 1'b0, 1'b0);
        pdn_pin = 1'b0; @(negedge clk);
        check("R2 pin release alone", 1'b0, 1'b0);
    endtask

    task automatic t_wake_tx();
        pulse_tx();
        check("R3 tx wake / R8 first tx", 1'b1, 1'b0);
        pulse_rx();
        check("R8 rx not counted", 1'b1, 1'b0);
        pulse_tx();
        check("R8 second tx enables", 1'b1, 1'b1);
    endtask

    task automatic t_pin_drop();
        force_down();
        check("R2 pin forces down / R7", 1'b0, 1'b0);
        pulse_tx();
        check("R9 count cleared", 1'b1, 1'b0);
        pulse_tx();
        check("R9 two new tx", 1'b1, 1'b1);
        force_down();
    endtask

    task automatic t_wake_rx();
        pulse_rx();
        check("R3 rx wake", 1'b1, 1'b0);
        pulse_tx();
        check("R8 one tx after rx wake", 1'b1, 1'b0);
        pulse_tx();
        check("R8 two tx after rx wake", 1'b1, 1'b1);
        force_down();
    endtask

    task automatic t_held_high();
        tx_sync = 1'b1;
        idle(6);
        check("R6 held high counts once", 1'b1, 1'b0);
        tx_sync = 1'b0; @(negedge clk);
        pulse_tx();
        check("R6 next edge is second", 1'b1, 1'b1);
        force_down();
    endtask

    task automatic t_timeout();
        pulse_tx();
        pulse_tx();
        idle(T_OUT - 2);
        check("R5 up just before timeout", 1'b1, 1'b1);
        idle(1);
        check("R5 down at timeout / R7", 1'b0, 1'b0);
    endtask

    task automatic t_restart();
        pulse_rx();
        idle(T_OUT - 6);
        pulse_rx();
        idle(T_OUT - 2);
        check("R5 restarted count holds", 1'b1, 1'b0);
        idle(1);
        check("R5 restarted count expires", 1'b0, 1'b0);
        pulse_tx();
        check("R9 after timeout", 1'b1, 1'b0);
        force_down();
    endtask

    initial begin
        fork
            begin
                idle(3);
                t_reset();
                t_stay_down();
                t_pin_blocks();
                t_wake_tx();
                t_pin_drop();
                t_wake_rx();
                t_held_high();
                t_timeout();
                t_restart();
                done = 1'b1;
            end
            begin
                repeat (20000) @(negedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: run did not complete");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule